// File: doc/BRIEF.md
# Transmit Buffer Watermark Request Controller

This block sits on the write side of the FIFO that carries data from system memory towards a storage card. It has two fill modes. In the external mode a system agent pushes 32-bit words into the FIFO. The block tells that agent when room is available: it raises a transfer request, and a sticky ready flag that software can clear and that can also raise an interrupt. In the internal mode the block fetches words itself over a simple request/acknowledge read port. Each fetch uses the next word address, and the block keeps fetching until the programmed byte count is used up. In this mode it gives the system no request and no ready indication.

The card side drains the FIFO one word at a time. A transfer that runs out of bytes ends with a one-cycle completion pulse. In multi-block operation with automatic stop enabled, that completion also produces a one-cycle stop-command pulse. A data error aborts the transfer at once. The block then discards the buffered data, raises an abort flag and keeps the system address at which the abandoned block began, so that software can restart from that address. An error never produces the stop-command pulse. A data-path soft reset clears the whole transfer state before a restart.

Top module: `tx_wm_ctrl`

## Requirements
- R1: In external mode (`cfg_idma_en`=0), while a transfer is active, `dma_req` is 1 exactly when free FIFO words (DEPTH minus fill) are strictly greater than `cfg_wml`. The output lags the fill level by one clock, and it is 0 while no transfer is active.
- R2: `bwr_stat` becomes 1 in the same cycle that `dma_req` rises. A one-cycle `bwr_clr` pulse clears it, and it returns one cycle later if the free-space condition still holds. A new `start` clears it.
- R3: `bwr_irq` is 1 only while `bwr_int_en` is 1. It follows the ready flag with the same timing, and `bwr_stat` is set whatever the enable.
- R4: In internal mode, `dma_req` and `bwr_stat` stay 0. `mst_req` fetches words starting at `cfg_sys_addr` and increments the address by 4 per acknowledged word, until `cfg_byte_cnt` bytes have been fetched.
- R5: When the last word of the byte count enters the FIFO and there is no error, `xfer_done` pulses for one cycle. `auto_stop` pulses in the same cycle only if `cfg_multi` and `cfg_auto_stop` are both 1.
- R6: `xfer_err` during an active transfer ends the transfer and empties the FIFO. It sets `abort_flag` and loads `abort_addr` with the start address of the block in progress (blocks are `cfg_blk_bytes` long). `xfer_done` and `auto_stop` stay 0.
- R7: `soft_rst` empties the FIFO, ends any transfer and clears `dma_req`, `bwr_stat`, `abort_flag` and `abort_addr`.
- R8: Words leave in arrival order. `card_data` holds the popped word from the clock after `card_pop`. A word pushed while no transfer is active is dropped.
- R9: After `rst`, `dma_req`, `bwr_stat`, `bwr_irq`, `card_avail`, `mst_req`, `xfer_done` and `abort_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| soft_rst | input | 1 | Data-path soft reset |
| start | input | 1 | Begins a transfer (ignored while one is active) |
| cfg_idma_en | input | 1 | 1 = internal fetch mode, 0 = external push mode |
| cfg_multi | input | 1 | Multi-block transfer |
| cfg_auto_stop | input | 1 | Automatic stop command allowed |
| cfg_wml | input | $clog2(DEPTH+1) | Watermark in words |
| cfg_byte_cnt | input | CNT_W | Total bytes, a nonzero multiple of 4 |
| cfg_blk_bytes | input | BLK_W | Block size in bytes, a multiple of 4 |
| cfg_sys_addr | input | AW | System start address |
| bwr_int_en | input | 1 | Ready interrupt enable |
| bwr_clr | input | 1 | Write-one-to-clear pulse for the ready flag |
| sys_wr_valid | input | 1 | External word push |
| sys_wr_data | input | DW | External word |
| dma_req | output | 1 | Transfer request to the external agent |
| bwr_stat | output | 1 | Sticky buffer-write-ready flag |
| bwr_irq | output | 1 | Ready interrupt |
| mst_req | output | 1 | Internal fetch request |
| mst_addr | output | AW | Internal fetch address |
| mst_ack | input | 1 | Fetch acknowledge, data valid |
| mst_rdata | input | DW | Fetched word |
| card_pop | input | 1 | Card side takes one word |
| card_data | output | DW | Word taken by the last pop |
| card_avail | output | 1 | FIFO not empty |
| xfer_err | input | 1 | Data transfer error |
| xfer_done | output | 1 | Completion pulse |
| auto_stop | output | 1 | Stop-command pulse |
| abort_flag | output | 1 | Transfer was aborted |
| abort_addr | output | AW | Start address of the abandoned block |

## Verification
The bench tests the watermark at the exact boundary: free space equal to the watermark, then one word above it. A design that compares with greater-or-equal would raise the request one word too early. It clears the ready flag while the free space is still above the watermark. A design with no re-set path would leave the flag low, and one that lets the set override the clear would never show the one-cycle drop. It raises an error in the middle of the third block of an internal transfer with multi-block auto-stop enabled. A wrong block-start latch reports the fetch address rather than 0x2010, and a missing guard emits a stop pulse or a completion pulse. Pushes while idle, and a soft reset during a live transfer, expose designs that keep stale words or a lingering request.

// File: rtl/tx_wm_pkg.sv
package tx_wm_pkg;
  localparam int WORD_BYTES = 4;
endpackage

// File: rtl/tx_wm_fifo.sv
module tx_wm_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              rdata,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign do_push = push && (fill != CW'(DEPTH));
  assign do_pop  = pop && (fill != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
    if (do_pop)  rdata     <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/tx_wm_track.sv
module tx_wm_track
  import tx_wm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16,
  parameter int BLK_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [AW-1:0]    load_addr,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic [BLK_W-1:0] blk_bytes,
  input  logic             word_in,
  output logic [AW-1:0]    cur_addr,
  output logic [AW-1:0]    blk_start,
  output logic [CNT_W-1:0] remaining
);
  logic [BLK_W-1:0] blk_off;
  logic [BLK_W-1:0] off_next;

  assign off_next = blk_off + BLK_W'(WORD_BYTES);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur_addr  <= '0;
      blk_start <= '0;
      remaining <= '0;
      blk_off   <= '0;
    end else if (load) begin
      cur_addr  <= load_addr;
      blk_start <= load_addr;
      remaining <= load_cnt;
      blk_off   <= '0;
    end else if (word_in) begin
      cur_addr  <= cur_addr + AW'(WORD_BYTES);
      remaining <= remaining - CNT_W'(WORD_BYTES);
      if (off_next == blk_bytes) begin
        blk_off   <= '0;
        blk_start <= cur_addr + AW'(WORD_BYTES);
      end else begin
        blk_off <= off_next;
      end
    end
  end
endmodule

// File: rtl/tx_wm_flag.sv
module tx_wm_flag (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic cond,
  input  logic clr,
  input  logic int_en,
  output logic req,
  output logic stat,
  output logic irq
);
  logic rise, stat_n;

  assign rise   = cond && !req;
  assign stat_n = rise || ((cond || stat) && !clr);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      req  <= 1'b0;
      stat <= 1'b0;
      irq  <= 1'b0;
    end else begin
      req  <= cond;
      stat <= stat_n;
      irq  <= stat_n && int_en;
    end
  end
endmodule

// File: rtl/tx_wm_ctrl.sv
module tx_wm_ctrl
  import tx_wm_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  parameter int BLK_W = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       soft_rst,
  input  logic                       start,
  input  logic                       cfg_idma_en,
  input  logic                       cfg_multi,
  input  logic                       cfg_auto_stop,
  input  logic [$clog2(DEPTH+1)-1:0] cfg_wml,
  input  logic [CNT_W-1:0]           cfg_byte_cnt,
  input  logic [BLK_W-1:0]           cfg_blk_bytes,
  input  logic [AW-1:0]              cfg_sys_addr,
  input  logic                       bwr_int_en,
  input  logic                       bwr_clr,
  input  logic                       sys_wr_valid,
  input  logic [DW-1:0]              sys_wr_data,
  output logic                       dma_req,
  output logic                       bwr_stat,
  output logic                       bwr_irq,
  output logic                       mst_req,
  output logic [AW-1:0]              mst_addr,
  input  logic                       mst_ack,
  input  logic [DW-1:0]              mst_rdata,
  input  logic                       card_pop,
  output logic [DW-1:0]              card_data,
  output logic                       card_avail,
  input  logic                       xfer_err,
  output logic                       xfer_done,
  output logic                       auto_stop,
  output logic                       abort_flag,
  output logic [AW-1:0]              abort_addr
);
  localparam int CW = $clog2(DEPTH+1);

  logic             active_q;
  logic [CW-1:0]    fill;
  logic [CW-1:0]    free_words;
  logic [AW-1:0]    blk_start;
  logic [CNT_W-1:0] remaining;
  logic             full, have_bytes;
  logic             start_acc, push_ext, fetch_acc, word_in, err_hit, last_word;
  logic             wm_cond;
  logic [DW-1:0]    word_data;

  assign full       = (fill == CW'(DEPTH));
  assign have_bytes = (remaining != '0);
  assign free_words = CW'(DEPTH) - fill;
  assign start_acc  = start && !active_q && !soft_rst;
  assign push_ext   = sys_wr_valid && active_q && !cfg_idma_en && !full && have_bytes;
  assign mst_req    = active_q && cfg_idma_en && !full && have_bytes;
  assign fetch_acc  = mst_req && mst_ack;
  assign word_in    = push_ext || fetch_acc;
  assign word_data  = cfg_idma_en ? mst_rdata : sys_wr_data;
  assign err_hit    = xfer_err && active_q;
  assign last_word  = word_in && (remaining == CNT_W'(WORD_BYTES));
  assign wm_cond    = active_q && !cfg_idma_en && (free_words > cfg_wml);
  assign card_avail = (fill != '0);

  tx_wm_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (soft_rst || err_hit || start_acc),
    .push  (word_in && !err_hit),
    .wdata (word_data),
    .pop   (card_pop),
    .rdata (card_data),
    .fill  (fill)
  );

  tx_wm_track #(.AW(AW), .CNT_W(CNT_W), .BLK_W(BLK_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .clr       (soft_rst),
    .load      (start_acc),
    .load_addr (cfg_sys_addr),
    .load_cnt  (cfg_byte_cnt),
    .blk_bytes (cfg_blk_bytes),
    .word_in   (word_in),
    .cur_addr  (mst_addr),
    .blk_start (blk_start),
    .remaining (remaining)
  );

  tx_wm_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .flush  (soft_rst || start_acc),
    .cond   (wm_cond),
    .clr    (bwr_clr),
    .int_en (bwr_int_en),
    .req    (dma_req),
    .stat   (bwr_stat),
    .irq    (bwr_irq)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      active_q   <= 1'b0;
      xfer_done  <= 1'b0;
      auto_stop  <= 1'b0;
      abort_flag <= 1'b0;
      abort_addr <= '0;
    end else begin
      xfer_done <= 1'b0;
      auto_stop <= 1'b0;
      if (start_acc) begin
        active_q   <= 1'b1;
        abort_flag <= 1'b0;
      end else if (err_hit) begin
        active_q   <= 1'b0;
        abort_flag <= 1'b1;
        abort_addr <= blk_start;
      end else if (last_word) begin
        active_q  <= 1'b0;
        xfer_done <= 1'b1;
        auto_stop <= cfg_multi && cfg_auto_stop;
      end
    end
  end
endmodule

// File: rtl/tx_wm_chk.sv
module tx_wm_chk #(
  parameter int AW    = 32,
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       soft_rst,
  input logic                       cfg_idma_en,
  input logic                       active_q,
  input logic                       dma_req,
  input logic                       bwr_stat,
  input logic                       bwr_irq,
  input logic                       bwr_int_en,
  input logic                       xfer_err,
  input logic                       xfer_done,
  input logic                       auto_stop,
  input logic                       mst_req,
  input logic                       mst_ack,
  input logic [AW-1:0]              mst_addr,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  AST_REQ_WITH_STAT: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> bwr_stat); // R2
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    bwr_irq |-> $past(bwr_int_en)); // R3
  AST_IDMA_SILENT: assert property (@(posedge clk) disable iff (rst)
    (active_q && cfg_idma_en) |=> (!dma_req && !bwr_stat)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mst_req && mst_ack && !soft_rst) |=> (mst_addr == $past(mst_addr) + 4)); // R4
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> !active_q); // R5
  AST_NO_STOP_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    (xfer_err && active_q) |=> (!auto_stop && !xfer_done)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fill <= ($clog2(DEPTH+1))'(DEPTH)); // R8
endmodule

bind tx_wm_ctrl tx_wm_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .soft_rst    (soft_rst),
  .cfg_idma_en (cfg_idma_en),
  .active_q    (active_q),
  .dma_req     (dma_req),
  .bwr_stat    (bwr_stat),
  .bwr_irq     (bwr_irq),
  .bwr_int_en  (bwr_int_en),
  .xfer_err    (xfer_err),
  .xfer_done   (xfer_done),
  .auto_stop   (auto_stop),
  .mst_req     (mst_req),
  .mst_ack     (mst_ack),
  .mst_addr    (mst_addr),
  .fill        (fill)
);

// File: tb/test_tx_wm_ctrl.sv
module test_tx_wm_ctrl;
  localparam int DW = 32, AW = 32, DEPTH = 8, CNT_W = 16, BLK_W = 12;
  localparam int CW = $clog2(DEPTH+1);

  logic clk = 1'b0;
  logic rst = 1'b1, soft_rst = 1'b0, start = 1'b0;
  logic cfg_idma_en = 1'b0, cfg_multi = 1'b0, cfg_auto_stop = 1'b0;
  logic [CW-1:0] cfg_wml = CW'(3);
  logic [CNT_W-1:0] cfg_byte_cnt = '0;
  logic [BLK_W-1:0] cfg_blk_bytes = '0;
  logic [AW-1:0] cfg_sys_addr = '0;
  logic bwr_int_en = 1'b0, bwr_clr = 1'b0, sys_wr_valid = 1'b0;
  logic [DW-1:0] sys_wr_data = '0;
  logic dma_req, bwr_stat, bwr_irq, mst_req, card_avail, xfer_done, auto_stop, abort_flag;
  logic [AW-1:0] mst_addr, abort_addr;
  logic mst_ack = 1'b0, card_pop = 1'b0, xfer_err = 1'b0;
  logic [DW-1:0] mst_rdata = '0;
  logic [DW-1:0] card_data;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tx_wm_ctrl #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .CNT_W(CNT_W), .BLK_W(BLK_W)) i_tx_wm_ctrl (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .start(start),
    .cfg_idma_en(cfg_idma_en), .cfg_multi(cfg_multi), .cfg_auto_stop(cfg_auto_stop),
    .cfg_wml(cfg_wml), .cfg_byte_cnt(cfg_byte_cnt), .cfg_blk_bytes(cfg_blk_bytes),
    .cfg_sys_addr(cfg_sys_addr), .bwr_int_en(bwr_int_en), .bwr_clr(bwr_clr),
    .sys_wr_valid(sys_wr_valid), .sys_wr_data(sys_wr_data), .dma_req(dma_req),
    .bwr_stat(bwr_stat), .bwr_irq(bwr_irq), .mst_req(mst_req), .mst_addr(mst_addr),
    .mst_ack(mst_ack), .mst_rdata(mst_rdata), .card_pop(card_pop), .card_data(card_data),
    .card_avail(card_avail), .xfer_err(xfer_err), .xfer_done(xfer_done),
    .auto_stop(auto_stop), .abort_flag(abort_flag), .abort_addr(abort_addr)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_word(logic [DW-1:0] d);
    sys_wr_valid = 1'b1;
    sys_wr_data  = d;
    step();
    sys_wr_valid = 1'b0;
  endtask

  task automatic pop_check(logic [DW-1:0] exp, string req);
    card_pop = 1'b1;
    step();
    card_pop = 1'b0;
    check(req, card_data, exp);
  endtask

  task automatic begin_xfer(bit idma, int bytes, int blk, logic [AW-1:0] addr, bit multi, bit ast);
    cfg_idma_en   = idma;
    cfg_byte_cnt  = CNT_W'(bytes);
    cfg_blk_bytes = BLK_W'(blk);
    cfg_sys_addr  = addr;
    cfg_multi     = multi;
    cfg_auto_stop = ast;
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 dma_req", 32'(dma_req), 0);
    check("R9 bwr_stat", 32'(bwr_stat), 0);
    check("R9 bwr_irq", 32'(bwr_irq), 0);
    check("R9 card_avail", 32'(card_avail), 0);
    check("R9 mst_req", 32'(mst_req), 0);
    check("R9 xfer_done", 32'(xfer_done), 0);
    check("R9 abort_flag", 32'(abort_flag), 0);
  endtask

  task automatic t_external();
    begin_xfer(1'b0, 32, 16, 32'h400, 1'b1, 1'b1);
    check("R1 req lags start", 32'(dma_req), 0);
    step();
    check("R1 req free 8 > 3", 32'(dma_req), 1);
    check("R2 stat with req", 32'(bwr_stat), 1);
    check("R3 irq disabled", 32'(bwr_irq), 0);
    for (int k = 0; k < 5; k++) push_word(32'hA0 + 32'(k));
    step();
    check("R1 req free 3 == wml", 32'(dma_req), 0);
    pop_check(32'hA0, "R8 first word");
    step();
    check("R1 req free 4 > wml", 32'(dma_req), 1);
    bwr_clr = 1'b1;
    step();
    bwr_clr = 1'b0;
    check("R2 stat cleared", 32'(bwr_stat), 0);
    step();
    check("R2 stat re-set", 32'(bwr_stat), 1);
    bwr_int_en = 1'b1;
    step();
    check("R3 irq enabled", 32'(bwr_irq), 1);
    bwr_int_en = 1'b0;
    step();
    check("R3 irq masked", 32'(bwr_irq), 0);
    check("R3 stat kept", 32'(bwr_stat), 1);
    push_word(32'hA5);
    push_word(32'hA6);
    check("R5 no early done", 32'(xfer_done), 0);
    push_word(32'hA7);
    check("R5 done pulse", 32'(xfer_done), 1);
    check("R5 auto stop multi", 32'(auto_stop), 1);
    step();
    check("R5 done one cycle", 32'(xfer_done), 0);
    check("R1 req idle", 32'(dma_req), 0);
    push_word(32'hEE);
    for (int k = 1; k < 8; k++) pop_check(32'hA0 + 32'(k), "R8 order");
    check("R8 idle push dropped", 32'(card_avail), 0);
  endtask

  task automatic run_fetch(int nwords, logic [AW-1:0] base, output int got, output bit saw_done,
                           output bit saw_stop);
    got = 0;
    saw_done = 1'b0;
    saw_stop = 1'b0;
    for (int i = 0; i < 40 && got < nwords && !saw_done; i++) begin
      if (mst_req) begin
        check("R4 fetch address", mst_addr, base + 32'(4 * got));
        mst_ack   = 1'b1;
        mst_rdata = mst_addr + 32'h5A000000;
        got++;
      end
      step();
      mst_ack = 1'b0;
      if (dma_req || bwr_stat) check("R4 silent in idma", {30'd0, dma_req, bwr_stat}, 0);
      if (xfer_done) saw_done = 1'b1;
      if (auto_stop) saw_stop = 1'b1;
    end
  endtask

  task automatic t_internal();
    int got;
    bit sd, ss;
    begin_xfer(1'b1, 24, 8, 32'h1000, 1'b0, 1'b1);
    run_fetch(99, 32'h1000, got, sd, ss);
    check("R4 word count", 32'(got), 6);
    check("R5 done idma", 32'(sd), 1);
    check("R5 no stop single", 32'(ss), 0);
    check("R4 fetch stops", 32'(mst_req), 0);
    for (int k = 0; k < 6; k++) pop_check(32'h1000 + 32'(4 * k) + 32'h5A000000, "R8 idma data");
  endtask

  task automatic t_error();
    int got;
    bit sd, ss;
    begin_xfer(1'b1, 32, 8, 32'h2000, 1'b1, 1'b1);
    run_fetch(5, 32'h2000, got, sd, ss);
    xfer_err = 1'b1;
    step();
    xfer_err = 1'b0;
    check("R6 abort flag", 32'(abort_flag), 1);
    check("R6 abort addr", abort_addr, 32'h2010);
    check("R6 fifo flushed", 32'(card_avail), 0);
    check("R6 no done", 32'(xfer_done), 0);
    check("R6 no auto stop", 32'(auto_stop), 0);
    check("R6 fetch halted", 32'(mst_req), 0);
    step();
    check("R6 no late stop", 32'(auto_stop), 0);
  endtask

  task automatic t_soft();
    soft_rst = 1'b1;
    step();
    soft_rst = 1'b0;
    check("R7 abort flag cleared", 32'(abort_flag), 0);
    check("R7 abort addr cleared", abort_addr, 0);
    begin_xfer(1'b0, 32, 16, 32'h800, 1'b0, 1'b0);
    push_word(32'h11);
    push_word(32'h22);
    check("R7 req before", 32'(dma_req), 1);
    soft_rst = 1'b1;
    step();
    soft_rst = 1'b0;
    check("R7 fifo empty", 32'(card_avail), 0);
    check("R7 req cleared", 32'(dma_req), 0);
    check("R7 stat cleared", 32'(bwr_stat), 0);
    step();
    check("R7 req stays low", 32'(dma_req), 0);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_external();
    t_internal();
    t_error();
    t_soft();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule